// File: doc/BRIEF.md
# Relocatable Priority Address Decoder

This block turns a 16-bit CPU address into at most one select line for the on-chip resources. The resources are:

- a debug firmware area,
- the internal register block,
- RAM,
- EEPROM,
- fixed flash,
- the paged flash window,
- the external bus.

The RAM, the register block and the EEPROM can each be moved at run time. Four small mapping registers, written through a plain configuration port, set their positions. Those registers also switch flash in or out and can hide flash from the lower half of the map. The chip integrator fixes the memory sizes on static configuration inputs. The block turns those sizes into region sizes and decides which base bits are compared.

When two resources claim the same address, a fixed priority picks the winner. Software can therefore place the register block on top of RAM and still reach every register. The mapping registers can be rewritten freely while the chip is in special mode. In normal mode each register accepts only its first write, and later writes are dropped without any indication. The one exception is the EEPROM enable bit, which can be written at any time. The decode itself is combinational from the address and the registered map. A register write therefore changes the decode from the clock edge that captures it.

Top module: `memmap_decoder`

## Requirements
- R1: At most one bit of `sel` is high at any time. The bit positions are: 0 debug, 1 register block, 2 RAM, 3 EEPROM, 4 fixed flash, 5 paged window, 6 external.
- R2: When several resources match one address, the winner is chosen in this order, highest first: debug, register block, RAM, EEPROM, fixed flash, paged window, external.
- R3: While `debug_active` is high, addresses 0xFF00 to 0xFFFF select debug.
- R4: Configuration index 1, data bits 6:3, sets register-block address bits 14:11. Address bit 15 of the block is always zero, so data bit 7 is ignored. When `cfg_reg_2k` is 1 the block covers a 2K slot. When it is 0 the block covers only the lower 1K of that slot.
- R5: Configuration index 0 holds the RAM position: data bits 7:3 are base bits 15:11 and bit 0 is the high-align flag. The RAM size is (`cfg_ram_size`+1)×2K. For codes 0 to 7 the region is 2K, 4K, 8K, 8K, 16K, 16K, 16K and 16K, and only the base bits above the region size are compared. The RAM sits at the bottom of its region when the flag is 0 and at the top when it is 1.
- R6: Configuration index 2 holds the EEPROM position: data bits 7:3 are base bits 15:11 and bit 0 is the enable. The value of `cfg_ee_size` sets the size: 0 gives 0K, 1 gives 2K and 2 gives 4K. The EEPROM is selected only when it is enabled and its size is not zero.
- R7: Configuration index 3 controls flash: bit 0 is the enable and bit 1 is high-half-only.
  - `cfg_flash_size` 1 gives fixed flash at 0xC000–0xFFFF.
  - `cfg_flash_size` 2 adds 0x4000–0x7FFF.
  - `cfg_flash_size` 3 adds 0x0000–0x7FFF.
  - Sizes 2 and 3 also select the paged window at 0x8000–0xBFFF.
  - High-half-only removes the fixed areas below 0x8000.
  - A cleared enable removes all flash selects.
- R8: In normal mode (`mode_special`=0), each mapping register accepts only its first write after reset. Later normal-mode writes are ignored, except for the EEPROM enable bit. In special mode every write is accepted, and a special-mode write does not lock the register.
- R9: A mapping write changes the decode at the rising edge that captures it, and not before.
- R10: An address that no internal resource claims selects external when `mode_expanded` is 1. When `mode_expanded` is 0, such an address leaves `sel` all zero.
- R11: After reset the registers hold these values and every lock is cleared:
  - RAM position: 0x09.
  - Register position: 0x00.
  - EEPROM position: 0x11.
  - Flash control: 0x01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_special | input | 1 | 1 = special mode (mapping registers always writable) |
| mode_expanded | input | 1 | 1 = expanded mode (unclaimed addresses go external) |
| debug_active | input | 1 | Enables the debug firmware area |
| cfg_reg_2k | input | 1 | Register block size: 1 = 2K, 0 = 1K |
| cfg_ram_size | input | 3 | RAM size code |
| cfg_ee_size | input | 2 | EEPROM size code |
| cfg_flash_size | input | 2 | Fixed flash size code |
| cfg_we | input | 1 | Mapping register write strobe |
| cfg_idx | input | 2 | Mapping register index |
| cfg_wdata | input | 8 | Mapping register write data |
| addr | input | 16 | CPU address to decode |
| sel | output | 7 | Select vector with at most one bit set |

## Verification
A table of addresses sweeps every flash size code with the reset map. It separates fixed flash from the paged window and from the external bus, and it shows the register block and RAM hiding the EEPROM at their reset positions.

Directed write sequences then cover the following:
- They move RAM, EEPROM and the register block, and probe the edges of each range. This tells the size-dependent base masking apart from the high-align placement and from the 1K and 2K register sizes.
- Repeated writes in normal mode and in special mode tell the write-once lock apart from the EEPROM enable bit, which is always writable.
- A check made before the capturing edge and another made after it pin down when a write takes effect.
- Clearing `mode_expanded` and raising `debug_active` show the ends of the priority chain.

// File: rtl/mm_pkg.sv
package mm_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int NUM_SEL = 7;
  localparam int NUM_WIN = 3;
  localparam int NUM_REG = 4;

  localparam int SEL_DBG   = 0;
  localparam int SEL_REG   = 1;
  localparam int SEL_RAM   = 2;
  localparam int SEL_EE    = 3;
  localparam int SEL_FLASH = 4;
  localparam int SEL_WIN   = 5;
  localparam int SEL_EXT   = 6;

  typedef enum logic [1:0] {
    IDX_RAM   = 2'd0,
    IDX_REG   = 2'd1,
    IDX_EE    = 2'd2,
    IDX_FLASH = 2'd3
  } map_idx_e;

  typedef enum logic [1:0] {
    FSZ_NONE = 2'd0,
    FSZ_TOP  = 2'd1,
    FSZ_3Q   = 2'd2,
    FSZ_FULL = 2'd3
  } flash_size_e;

  typedef struct packed {
    logic [4:0] ram_base;
    logic       ram_hal;
    logic [3:0] reg_base;
    logic [4:0] ee_base;
    logic       ee_en;
    logic       flash_hh;
    logic       flash_en;
  } map_state_t;

  function automatic logic [3:0] ram_region_log2(input logic [2:0] code);
    case (code)
      3'd0:        return 4'd11;
      3'd1:        return 4'd12;
      3'd2, 3'd3:  return 4'd13;
      default:     return 4'd14;
    endcase
  endfunction

  function automatic logic [4:0] ram_alloc_kb(input logic [2:0] code);
    return ({2'b00, code} + 5'd1) << 1;
  endfunction
endpackage

// File: rtl/mm_map_regs.sv
module mm_map_regs
  import mm_pkg::*;
#(
  parameter logic [7:0] RAM_RESET   = 8'h09,
  parameter logic [7:0] REG_RESET   = 8'h00,
  parameter logic [7:0] EE_RESET    = 8'h11,
  parameter logic [7:0] FLASH_RESET = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_special,
  input  logic              we,
  input  logic [1:0]        idx,
  input  logic [DATA_W-1:0] wdata,
  output map_state_t        state,
  output logic [NUM_REG-1:0] lock
);
  logic wr_ok;

  assign wr_ok = mode_special | ~lock[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state.ram_base <= RAM_RESET[7:3];
      state.ram_hal  <= RAM_RESET[0];
      state.reg_base <= REG_RESET[6:3];
      state.ee_base  <= EE_RESET[7:3];
      state.ee_en    <= EE_RESET[0];
      state.flash_hh <= FLASH_RESET[1];
      state.flash_en <= FLASH_RESET[0];
    end else if (we) begin
      case (map_idx_e'(idx))
        IDX_RAM: if (wr_ok) begin
          state.ram_base <= wdata[7:3];
          state.ram_hal  <= wdata[0];
        end
        IDX_REG: if (wr_ok) state.reg_base <= wdata[6:3];
        IDX_EE: begin
          if (wr_ok) state.ee_base <= wdata[7:3];
          state.ee_en <= wdata[0];
        end
        default: if (wr_ok) begin
          state.flash_hh <= wdata[1];
          state.flash_en <= wdata[0];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock <= '0;
    end else if (we && !mode_special) begin
      lock[idx] <= 1'b1;
    end
  end
endmodule

// File: rtl/mm_window_match.sv
module mm_window_match
  import mm_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [4:0]        base,
  input  logic [3:0]        rlog,
  input  logic [4:0]        alloc_kb,
  input  logic              hal,
  input  logic              enable,
  output logic              hit
);
  logic [16:0]       rsize;
  logic [15:0]       omask;
  logic [15:0]       base16;
  logic              in_region;
  logic [16:0]       offs;
  logic [16:0]       abytes;
  logic              fits;

  assign rsize     = 17'd1 << rlog;
  assign omask     = rsize[15:0] - 16'd1;
  assign base16    = {base, 11'd0};
  assign in_region = ((addr ^ base16) & ~omask) == 16'd0;
  assign offs      = {1'b0, addr & omask};
  assign abytes    = {2'b00, alloc_kb, 10'd0};
  assign fits      = hal ? (offs >= (rsize - abytes)) : (offs < abytes);
  assign hit       = enable & in_region & fits;
endmodule

// File: rtl/mm_flash_match.sv
module mm_flash_match
  import mm_pkg::*;
(
  input  logic [1:0] quad,
  input  logic [1:0] size_code,
  input  logic       flash_en,
  input  logic       flash_hh,
  output logic       fixed_hit,
  output logic       win_hit
);
  logic top_q, win_q, upper_low_q, lower_low_q;

  assign top_q       = quad == 2'b11;
  assign win_q       = quad == 2'b10;
  assign upper_low_q = quad == 2'b01;
  assign lower_low_q = quad == 2'b00;

  always_comb begin
    fixed_hit = 1'b0;
    win_hit   = 1'b0;
    case (flash_size_e'(size_code))
      FSZ_TOP: fixed_hit = top_q;
      FSZ_3Q: begin
        fixed_hit = top_q | (upper_low_q & ~flash_hh);
        win_hit   = win_q;
      end
      FSZ_FULL: begin
        fixed_hit = top_q | ((upper_low_q | lower_low_q) & ~flash_hh);
        win_hit   = win_q;
      end
      default: ;
    endcase
    fixed_hit = fixed_hit & flash_en;
    win_hit   = win_hit & flash_en;
  end
endmodule

// File: rtl/mm_priority_sel.sv
module mm_priority_sel #(
  parameter int N = 7
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [N-1:0] higher;

  assign higher[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_lane
    assign gnt[i] = req[i] & ~higher[i];
    if (i < N - 1) begin : g_chain
      assign higher[i+1] = higher[i] | req[i];
    end
  end
endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
  import mm_pkg::*;
#(
  parameter logic [15:0] DBG_BASE    = 16'hFF00,
  parameter int          DBG_LOG2    = 8,
  parameter logic [7:0]  RAM_RESET   = 8'h09,
  parameter logic [7:0]  REG_RESET   = 8'h00,
  parameter logic [7:0]  EE_RESET    = 8'h11,
  parameter logic [7:0]  FLASH_RESET = 8'h01
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_special,
  input  logic               mode_expanded,
  input  logic               debug_active,
  input  logic               cfg_reg_2k,
  input  logic [2:0]         cfg_ram_size,
  input  logic [1:0]         cfg_ee_size,
  input  logic [1:0]         cfg_flash_size,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_idx,
  input  logic [DATA_W-1:0]  cfg_wdata,
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_SEL-1:0] sel
);
  localparam int DBG_HI = ADDR_W - 1;

  map_state_t         map_st;
  logic [NUM_REG-1:0] lock_vec;

  logic [4:0] m_base  [NUM_WIN];
  logic [3:0] m_rlog  [NUM_WIN];
  logic [4:0] m_alloc [NUM_WIN];
  logic       m_hal   [NUM_WIN];
  logic       m_en    [NUM_WIN];
  logic [NUM_WIN-1:0] m_hit;

  logic dbg_hit, fixed_hit, win_hit;
  logic [NUM_SEL-1:0] req;

  mm_map_regs #(
    .RAM_RESET  (RAM_RESET),
    .REG_RESET  (REG_RESET),
    .EE_RESET   (EE_RESET),
    .FLASH_RESET(FLASH_RESET)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_special(mode_special),
    .we          (cfg_we),
    .idx         (cfg_idx),
    .wdata       (cfg_wdata),
    .state       (map_st),
    .lock        (lock_vec)
  );

  // lane 0: register block, lane 1: RAM, lane 2: EEPROM
  always_comb begin
    m_base[0]  = {1'b0, map_st.reg_base};
    m_rlog[0]  = 4'd11;
    m_alloc[0] = cfg_reg_2k ? 5'd2 : 5'd1;
    m_hal[0]   = 1'b0;
    m_en[0]    = 1'b1;

    m_base[1]  = map_st.ram_base;
    m_rlog[1]  = ram_region_log2(cfg_ram_size);
    m_alloc[1] = ram_alloc_kb(cfg_ram_size);
    m_hal[1]   = map_st.ram_hal;
    m_en[1]    = 1'b1;

    m_base[2]  = map_st.ee_base;
    m_rlog[2]  = (cfg_ee_size == 2'd2) ? 4'd12 : 4'd11;
    m_alloc[2] = (cfg_ee_size == 2'd2) ? 5'd4 : 5'd2;
    m_hal[2]   = 1'b0;
    m_en[2]    = map_st.ee_en & ((cfg_ee_size == 2'd1) | (cfg_ee_size == 2'd2));
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    mm_window_match u_match (
      .addr    (addr),
      .base    (m_base[w]),
      .rlog    (m_rlog[w]),
      .alloc_kb(m_alloc[w]),
      .hal     (m_hal[w]),
      .enable  (m_en[w]),
      .hit     (m_hit[w])
    );
  end

  mm_flash_match u_flash (
    .quad     (addr[15:14]),
    .size_code(cfg_flash_size),
    .flash_en (map_st.flash_en),
    .flash_hh (map_st.flash_hh),
    .fixed_hit(fixed_hit),
    .win_hit  (win_hit)
  );

  assign dbg_hit = debug_active & (addr[DBG_HI:DBG_LOG2] == DBG_BASE[DBG_HI:DBG_LOG2]);

  always_comb begin
    req            = '0;
    req[SEL_DBG]   = dbg_hit;
    req[SEL_REG]   = m_hit[0];
    req[SEL_RAM]   = m_hit[1];
    req[SEL_EE]    = m_hit[2];
    req[SEL_FLASH] = fixed_hit;
    req[SEL_WIN]   = win_hit;
    req[SEL_EXT]   = mode_expanded;
  end

  mm_priority_sel #(.N(NUM_SEL)) u_prio (
    .req(req),
    .gnt(sel)
  );
endmodule

// File: rtl/mm_decoder_chk.sv
module mm_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mode_special,
  input logic        mode_expanded,
  input logic        debug_active,
  input logic        cfg_we,
  input logic [1:0]  cfg_idx,
  input logic [15:0] addr,
  input logic [6:0]  sel,
  input logic [3:0]  lock_vec,
  input logic [5:0]  ram_cfg,
  input logic        flash_en
);
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  a_r10_expanded_one: assert property (@(posedge clk) disable iff (!rst_n)
    mode_expanded |-> $countones(sel) == 1);

  a_r10_single_no_ext: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_expanded |-> !sel[6]);

  a_r3_debug_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (debug_active && addr[15:8] == 8'hFF) |-> sel == 7'b0000001);

  a_r7_window_quarter: assert property (@(posedge clk) disable iff (!rst_n)
    sel[5] |-> addr[15:14] == 2'b10);

  a_r7_flash_off: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_en |-> sel[5:4] == 2'b00);

  a_r8_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !mode_special && cfg_idx == 2'd0 && lock_vec[0]) |=> $stable(ram_cfg));

  a_r8_lock_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !mode_special) |=> lock_vec[$past(cfg_idx)]);
endmodule

bind memmap_decoder mm_decoder_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_special (mode_special),
  .mode_expanded(mode_expanded),
  .debug_active (debug_active),
  .cfg_we       (cfg_we),
  .cfg_idx      (cfg_idx),
  .addr         (addr),
  .sel          (sel),
  .lock_vec     (lock_vec),
  .ram_cfg      ({map_st.ram_base, map_st.ram_hal}),
  .flash_en     (map_st.flash_en)
);

// File: tb/tb_memmap_decoder.sv
module tb_memmap_decoder;
  localparam logic [6:0] S_NONE = 7'b0000000;
  localparam logic [6:0] S_DBG  = 7'b0000001;
  localparam logic [6:0] S_REG  = 7'b0000010;
  localparam logic [6:0] S_RAM  = 7'b0000100;
  localparam logic [6:0] S_EE   = 7'b0001000;
  localparam logic [6:0] S_FL   = 7'b0010000;
  localparam logic [6:0] S_WIN  = 7'b0100000;
  localparam logic [6:0] S_EXT  = 7'b1000000;
  localparam int NVEC = 20;

  // {flash size code, address, expected select}
  localparam logic [24:0] VECS [NVEC] = '{
    {2'd3, 16'h0000, S_REG}, {2'd3, 16'h07FF, S_REG},
    {2'd3, 16'h0800, S_RAM}, {2'd3, 16'h1000, S_RAM},
    {2'd3, 16'h1FFF, S_RAM}, {2'd3, 16'h2000, S_FL},
    {2'd3, 16'h7FFF, S_FL},  {2'd3, 16'h8000, S_WIN},
    {2'd3, 16'hBFFF, S_WIN}, {2'd3, 16'hC000, S_FL},
    {2'd3, 16'hFFFF, S_FL},  {2'd0, 16'h2000, S_EXT},
    {2'd0, 16'h8000, S_EXT}, {2'd0, 16'hC000, S_EXT},
    {2'd1, 16'hC000, S_FL},  {2'd1, 16'h8000, S_EXT},
    {2'd1, 16'h4000, S_EXT}, {2'd2, 16'h4000, S_FL},
    {2'd2, 16'h2000, S_EXT}, {2'd2, 16'h8000, S_WIN}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_special = 1'b0;
  logic        mode_expanded = 1'b1;
  logic        debug_active = 1'b0;
  logic        cfg_reg_2k = 1'b1;
  logic [2:0]  cfg_ram_size = 3'd3;
  logic [1:0]  cfg_ee_size = 2'd1;
  logic [1:0]  cfg_flash_size = 2'd3;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = 2'd0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [15:0] addr = 16'h0000;
  logic [6:0]  sel;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  memmap_decoder dut (
    .clk(clk), .rst_n(rst_n), .mode_special(mode_special),
    .mode_expanded(mode_expanded), .debug_active(debug_active),
    .cfg_reg_2k(cfg_reg_2k), .cfg_ram_size(cfg_ram_size),
    .cfg_ee_size(cfg_ee_size), .cfg_flash_size(cfg_flash_size),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .addr(addr), .sel(sel)
  );

  task automatic chk(input logic [15:0] a, input logic [6:0] exp, input string tag);
    addr = a;
    #1;
    checks++;
    if (sel !== exp) begin
      failures++;
      $display("FAIL %s addr=%h actual=%b expected=%b", tag, a, sel, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [7:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset map, R2 overlaps, R7 flash sizes, R10 unclaimed space
    for (int i = 0; i < NVEC; i++) begin
      cfg_flash_size = VECS[i][24:23];
      chk(VECS[i][22:7], VECS[i][6:0], $sformatf("R11 R7 table[%0d]", i));
    end
    cfg_flash_size = 2'd3;

    // R9: no effect before the capturing edge, effect after it (R5 move RAM to 0x4000)
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'd0; cfg_wdata = 8'h40;
    chk(16'h4000, S_FL, "R9 before edge");
    @(negedge clk);
    cfg_we = 1'b0;
    chk(16'h4000, S_RAM, "R9 after edge");
    chk(16'h5FFF, S_RAM, "R5 top of moved RAM");
    chk(16'h6000, S_FL, "R5 above moved RAM");
    chk(16'h0800, S_FL, "R5 old RAM area vacated");
    chk(16'h1000, S_EE, "R6 EEPROM uncovered");

    // R8 second normal write ignored
    wr(2'd0, 8'h00);
    chk(16'h4000, S_RAM, "R8 RAM lock");
    chk(16'h0800, S_FL, "R8 RAM lock old area");

    // R6 and R8 EEPROM base lock, enable always writable
    wr(2'd2, 8'h31);
    chk(16'h3000, S_EE, "R6 EEPROM moved");
    chk(16'h1000, S_FL, "R6 EEPROM old area");
    wr(2'd2, 8'h50);
    chk(16'h3000, S_FL, "R8 EEPROM enable cleared");
    chk(16'h5000, S_RAM, "R8 EEPROM base not moved");
    wr(2'd2, 8'h51);
    chk(16'h3000, S_EE, "R8 EEPROM re-enabled at locked base");
    cfg_ee_size = 2'd2;
    chk(16'h3800, S_EE, "R6 EEPROM 4K");
    cfg_ee_size = 2'd0;
    chk(16'h3000, S_FL, "R6 EEPROM 0K");
    cfg_ee_size = 2'd1;
    chk(16'h3800, S_FL, "R6 EEPROM 2K end");

    // R4 register block
    wr(2'd1, 8'hE0);
    chk(16'h6000, S_REG, "R4 reg block base");
    chk(16'h67FF, S_REG, "R4 reg block 2K end");
    chk(16'hE000, S_FL, "R4 bit15 forced zero");
    cfg_reg_2k = 1'b0;
    chk(16'h63FF, S_REG, "R4 reg block 1K end");
    chk(16'h6400, S_FL, "R4 reg block 1K limit");
    mode_special = 1'b1;
    wr(2'd1, 8'h40);
    chk(16'h4000, S_REG, "R2 regs over RAM");
    chk(16'h4400, S_RAM, "R4 1K block leaves RAM");

    // R5 high-align with 6K in 8K region, special-mode rewrites (R8)
    cfg_ram_size = 3'd2;
    wr(2'd0, 8'h01);
    chk(16'h0800, S_RAM, "R5 high-align bottom");
    chk(16'h07FF, S_FL, "R5 high-align gap");
    chk(16'h1FFF, S_RAM, "R5 high-align top");
    wr(2'd0, 8'h00);
    chk(16'h17FF, S_RAM, "R5 low-align top");
    chk(16'h1800, S_FL, "R5 low-align gap");

    // R7 flash control
    wr(2'd3, 8'h03);
    chk(16'h2000, S_EXT, "R7 high-half-only low quarter");
    chk(16'h7000, S_EXT, "R7 high-half-only second quarter");
    chk(16'hC000, S_FL, "R7 high-half-only top");
    chk(16'h8000, S_WIN, "R7 window kept");
    mode_special = 1'b0;
    wr(2'd3, 8'h02);
    chk(16'hC000, S_EXT, "R7 flash disabled top");
    chk(16'h9000, S_EXT, "R7 flash disabled window");
    wr(2'd3, 8'h01);
    chk(16'hC000, S_EXT, "R8 flash control lock");

    // R10 single-chip mode
    mode_expanded = 1'b0;
    chk(16'hC000, S_NONE, "R10 single-chip unclaimed");
    chk(16'h0800, S_RAM, "R10 single-chip internal");

    // R3 debug area
    debug_active = 1'b1;
    chk(16'hFF80, S_DBG, "R3 debug area");
    chk(16'hFE00, S_NONE, "R3 below debug area");
    mode_expanded = 1'b1;
    chk(16'hFEFF, S_EXT, "R3 below debug expanded");
    mode_special = 1'b1;
    wr(2'd3, 8'h01);
    mode_special = 1'b0;
    chk(16'hFF00, S_DBG, "R2 debug over flash");
    chk(16'hFEFF, S_FL, "R2 flash below debug");
    debug_active = 1'b0;
    chk(16'hFF00, S_FL, "R3 debug off");

    // R11 second reset restores map and clears locks
    @(negedge clk);
    rst_n = 1'b0;
    cfg_ram_size = 3'd3;
    cfg_reg_2k = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(16'h0000, S_REG, "R11 reg block reset");
    chk(16'h0800, S_RAM, "R11 RAM reset");
    chk(16'h1000, S_RAM, "R11 EEPROM hidden at reset");
    chk(16'hC000, S_FL, "R11 flash reset");
    wr(2'd3, 8'h00);
    chk(16'hC000, S_EXT, "R11 lock cleared by reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule